// File: doc/BRIEF.md
# Multi-Lock Hardware Mutex Bank with Owner IDs

This block holds a bank of lock entries that several processors share. Each processor reaches the bank through its own simple register port. A fixed CPU ID is tied to each port by parameter. To take a lock, a processor writes the lock's entry with the request bit set. It then reads the entry back to find out whether the stored owner is its own ID. To give a lock back, it writes the entry with the request bit clear.

Every lock remembers the ID of the CPU that holds it. A release or lock request from any other CPU leaves the entry as it is, so one processor cannot free a lock it does not hold. When several ports ask for the same free lock in one cycle, the port with the lowest number wins. Each lock is an independent cell, so requests to different locks in the same cycle do not interact. The bank supports up to 32 locks and up to eight ports, both set by parameter.

Top module: `hw_lock_bank`

## Requirements
- R1: Reset (synchronous, active high) leaves every lock free with owner 0, so any read after reset returns 4'h0.
- R2: A read (`acc_en`=1, `acc_we`=0) raises `rsp_valid` on that port one cycle later. `rsp_data` then carries the entry's bit 0 = locked and bits 3:1 = owner ID. The value is the one held before any write in the same cycle as the read.
- R3: A lock write (`acc_we`=1, `acc_wbit`=1) to a free lock makes it locked, with owner equal to the writing port's CPU ID, from the next cycle on.
- R4: A lock write to a lock that another CPU holds leaves the lock and its owner unchanged.
- R5: A lock write from the current owner leaves the entry unchanged.
- R6: A release write (`acc_we`=1, `acc_wbit`=0) from the port whose CPU ID equals the stored owner frees the lock and sets the owner to 0 from the next cycle on.
- R7: A release write from any other CPU, or a release write to a free lock, has no effect.
- R8: When two or more ports write lock requests to the same free lock in one cycle, only the lowest-numbered of those ports is granted the lock.
- R9: Requests to different locks in the same cycle are each decided on their own.
- R10: `rsp_valid` stays low in the cycle after a write or an idle cycle on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | N_PORTS | Per-port access strobe |
| acc_we | input | N_PORTS | Per-port write select (1 = write, 0 = read) |
| acc_idx | input | N_PORTS*IDX_W | Per-port lock index, port p at bits p*IDX_W upward |
| acc_wbit | input | N_PORTS | Per-port write value: 1 = request lock, 0 = release |
| rsp_valid | output | N_PORTS | Per-port read data valid, one cycle after a read |
| rsp_data | output | N_PORTS*4 | Per-port read entry: bit 0 locked, bits 3:1 owner |

## Verification
The assertions check these rules on every cycle:
- at most one port is granted any lock;
- a grant only reaches a free lock and always leaves it locked;
- a held lock keeps its owner until a matching release;
- a release always clears both the flag and the owner;
- read responses follow reads exactly.

Other behaviours can only be shown by the bench's scenarios against its reference model. These are the choice of which port wins, the exact owner ID that is stored, and a foreign release being refused. They also include a read returning the value from before a write in the same cycle, and the way interleaved random traffic from four ports settles.

// File: rtl/hwlock_pkg.sv
package hwlock_pkg;
  localparam int ID_W    = 3;
  localparam int ENTRY_W = 1 + ID_W;
  localparam int MAX_PORTS = 8;

  typedef struct packed {
    logic [ID_W-1:0] owner;
    logic            locked;
  } lock_entry_t;

  function automatic lock_entry_t f_entry(input logic locked, input logic [ID_W-1:0] owner);
    lock_entry_t e;
    e.locked = locked;
    e.owner  = owner;
    return e;
  endfunction

  // keep only the least significant set bit: this is the priority rule
  function automatic logic [MAX_PORTS-1:0] f_lowest_hot(input logic [MAX_PORTS-1:0] v);
    return v & (~v + {{(MAX_PORTS-1){1'b0}}, 1'b1});
  endfunction
endpackage

// File: rtl/lock_req_decode.sv
module lock_req_decode
  import hwlock_pkg::*;
#(
  parameter int N_LOCKS = 16,
  parameter int IDX_W   = 4
) (
  input  logic               en,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic               wbit,
  output logic [N_LOCKS-1:0] lock_hit,
  output logic [N_LOCKS-1:0] free_hit
);
  for (genvar l = 0; l < N_LOCKS; l++) begin : g_lock
    logic sel;
    assign sel         = en && we && (idx == IDX_W'(l));
    assign lock_hit[l] = sel && wbit;
    assign free_hit[l] = sel && !wbit;
  end
endmodule

// File: rtl/lock_cell.sv
module lock_cell
  import hwlock_pkg::*;
#(
  parameter int                      N_PORTS  = 4,
  parameter logic [N_PORTS*ID_W-1:0] PORT_IDS = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PORTS-1:0] lock_req,
  input  logic [N_PORTS-1:0] free_req,
  output lock_entry_t        entry,
  output logic [N_PORTS-1:0] grant_oh,
  output logic               release_ev
);
  logic [MAX_PORTS-1:0] hot;
  logic [N_PORTS-1:0]   owner_match;
  logic [ID_W-1:0]      win_id;

  assign hot      = f_lowest_hot(MAX_PORTS'(lock_req));
  assign grant_oh = entry.locked ? '0 : hot[N_PORTS-1:0];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_match
    assign owner_match[p] = free_req[p] && (PORT_IDS[p*ID_W +: ID_W] == entry.owner);
  end
  assign release_ev = entry.locked && (|owner_match);

  always_comb begin
    win_id = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (grant_oh[p]) win_id = win_id | PORT_IDS[p*ID_W +: ID_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              entry <= f_entry(1'b0, '0);
    else if (|grant_oh)   entry <= f_entry(1'b1, win_id);
    else if (release_ev)  entry <= f_entry(1'b0, '0);
  end
endmodule

// File: rtl/lock_read_port.sv
module lock_read_port
  import hwlock_pkg::*;
#(
  parameter int N_LOCKS = 16,
  parameter int IDX_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic [IDX_W-1:0]           idx,
  input  logic [N_LOCKS*ENTRY_W-1:0] entries,
  output logic                       rsp_valid,
  output logic [ENTRY_W-1:0]         rsp_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= entries[int'(idx)*ENTRY_W +: ENTRY_W];
    end
  end
endmodule

// File: rtl/hw_lock_bank.sv
module hw_lock_bank
  import hwlock_pkg::*;
#(
  parameter int                      N_PORTS  = 4,
  parameter int                      N_LOCKS  = 16,
  parameter logic [N_PORTS*ID_W-1:0] PORT_IDS = {3'd7, 3'd5, 3'd2, 3'd1},
  localparam int                     IDX_W    = (N_LOCKS > 1) ? $clog2(N_LOCKS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_PORTS-1:0]           acc_en,
  input  logic [N_PORTS-1:0]           acc_we,
  input  logic [N_PORTS*IDX_W-1:0]     acc_idx,
  input  logic [N_PORTS-1:0]           acc_wbit,
  output logic [N_PORTS-1:0]           rsp_valid,
  output logic [N_PORTS*ENTRY_W-1:0]   rsp_data
);
  // named internal events, observed by the bound checker
  logic [N_LOCKS-1:0]         lk_locked;
  logic [N_LOCKS*ID_W-1:0]    lk_owner;
  logic [N_LOCKS*N_PORTS-1:0] grant_flat;
  logic [N_LOCKS-1:0]         release_vec;
  logic [N_LOCKS*ENTRY_W-1:0] entries_flat;

  logic [N_LOCKS-1:0] port_lock_hit [N_PORTS];
  logic [N_LOCKS-1:0] port_free_hit [N_PORTS];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    lock_req_decode #(.N_LOCKS(N_LOCKS), .IDX_W(IDX_W)) u_dec (
      .en       (acc_en[p]),
      .we       (acc_we[p]),
      .idx      (acc_idx[p*IDX_W +: IDX_W]),
      .wbit     (acc_wbit[p]),
      .lock_hit (port_lock_hit[p]),
      .free_hit (port_free_hit[p])
    );
    lock_read_port #(.N_LOCKS(N_LOCKS), .IDX_W(IDX_W)) u_rd (
      .clk       (clk),
      .rst       (rst),
      .rd_en     (acc_en[p] && !acc_we[p]),
      .idx       (acc_idx[p*IDX_W +: IDX_W]),
      .entries   (entries_flat),
      .rsp_valid (rsp_valid[p]),
      .rsp_data  (rsp_data[p*ENTRY_W +: ENTRY_W])
    );
  end

  for (genvar l = 0; l < N_LOCKS; l++) begin : g_lock
    logic [N_PORTS-1:0] lreq;
    logic [N_PORTS-1:0] freq;
    lock_entry_t        ent;
    for (genvar p = 0; p < N_PORTS; p++) begin : g_t
      assign lreq[p] = port_lock_hit[p][l];
      assign freq[p] = port_free_hit[p][l];
    end
    lock_cell #(.N_PORTS(N_PORTS), .PORT_IDS(PORT_IDS)) u_cell (
      .clk        (clk),
      .rst        (rst),
      .lock_req   (lreq),
      .free_req   (freq),
      .entry      (ent),
      .grant_oh   (grant_flat[l*N_PORTS +: N_PORTS]),
      .release_ev (release_vec[l])
    );
    assign lk_locked[l]                      = ent.locked;
    assign lk_owner[l*ID_W +: ID_W]          = ent.owner;
    assign entries_flat[l*ENTRY_W +: ENTRY_W] = ent;
  end
endmodule

// File: rtl/hw_lock_bank_chk.sv
module hw_lock_bank_chk
  import hwlock_pkg::*;
#(
  parameter int N_PORTS = 4,
  parameter int N_LOCKS = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic [N_PORTS-1:0]           acc_en,
  input logic [N_PORTS-1:0]           acc_we,
  input logic [N_PORTS-1:0]           rsp_valid,
  input logic [N_LOCKS-1:0]           lk_locked,
  input logic [N_LOCKS*ID_W-1:0]      lk_owner,
  input logic [N_LOCKS*N_PORTS-1:0]   grant_flat,
  input logic [N_LOCKS-1:0]           release_vec
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (lk_locked == '0 && lk_owner == '0));

  for (genvar l = 0; l < N_LOCKS; l++) begin : g_l
    p_single_grant_r8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(grant_flat[l*N_PORTS +: N_PORTS]));
    p_grant_free_only_r4: assert property (@(posedge clk) disable iff (rst)
      (|grant_flat[l*N_PORTS +: N_PORTS]) |-> !lk_locked[l]);
    p_grant_sets_r3: assert property (@(posedge clk) disable iff (rst)
      (|grant_flat[l*N_PORTS +: N_PORTS]) |=> lk_locked[l]);
    p_hold_owner_r5: assert property (@(posedge clk) disable iff (rst)
      (lk_locked[l] && !release_vec[l]) |=> (lk_locked[l] && $stable(lk_owner[l*ID_W +: ID_W])));
    p_release_clears_r6: assert property (@(posedge clk) disable iff (rst)
      release_vec[l] |=> (!lk_locked[l] && lk_owner[l*ID_W +: ID_W] == '0));
    p_free_release_r7: assert property (@(posedge clk) disable iff (rst)
      !lk_locked[l] |-> !release_vec[l]);
  end

  for (genvar p = 0; p < N_PORTS; p++) begin : g_p
    p_read_resp_r2: assert property (@(posedge clk) disable iff (rst)
      (acc_en[p] && !acc_we[p]) |=> rsp_valid[p]);
    p_no_write_resp_r10: assert property (@(posedge clk) disable iff (rst)
      !(acc_en[p] && !acc_we[p]) |=> !rsp_valid[p]);
  end
endmodule

bind hw_lock_bank hw_lock_bank_chk #(.N_PORTS(N_PORTS), .N_LOCKS(N_LOCKS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_en      (acc_en),
  .acc_we      (acc_we),
  .rsp_valid   (rsp_valid),
  .lk_locked   (lk_locked),
  .lk_owner    (lk_owner),
  .grant_flat  (grant_flat),
  .release_vec (release_vec)
);

// File: tb/hw_lock_bank_bench.sv
module hw_lock_bank_bench;
  localparam int P  = 4;
  localparam int L  = 16;
  localparam int IW = 4;
  localparam logic [P*3-1:0] IDS = {3'd7, 3'd5, 3'd2, 3'd1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [P-1:0]    en, we, wbit;
  logic [P*IW-1:0] idx;
  logic [P-1:0]    rsp_valid;
  logic [P*4-1:0]  rsp_data;

  hw_lock_bank #(.N_PORTS(P), .N_LOCKS(L), .PORT_IDS(IDS)) u_hw_lock_bank (
    .clk(clk), .rst(rst), .acc_en(en), .acc_we(we), .acc_idx(idx),
    .acc_wbit(wbit), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  int m_locked [L];
  int m_owner  [L];
  int exp_v [P];
  int exp_d [P];
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  function automatic int pid(int p);
    return int'((IDS >> (3 * p)) & 12'h7);
  endfunction

  task automatic clr();
    en = '0; we = '0; wbit = '0; idx = '0;
  endtask

  task automatic op(int p, bit w, bit b, int l);
    en[p] = 1'b1; we[p] = w; wbit[p] = b; idx[p*IW +: IW] = IW'(l);
  endtask

  // reference: decide each lock from the state before this cycle's requests
  task automatic step(string tag);
    int nl [L];
    int no [L];
    for (int p = 0; p < P; p++) begin
      int l = int'(idx[p*IW +: IW]);
      exp_v[p] = (en[p] && !we[p]) ? 1 : 0;
      exp_d[p] = m_locked[l] + 2 * m_owner[l];
    end
    for (int l = 0; l < L; l++) begin
      nl[l] = m_locked[l]; no[l] = m_owner[l];
      if (m_locked[l] == 0) begin
        for (int p = P - 1; p >= 0; p--)
          if (en[p] && we[p] && wbit[p] && int'(idx[p*IW +: IW]) == l) begin
            nl[l] = 1; no[l] = pid(p);
          end
      end else begin
        for (int p = 0; p < P; p++)
          if (en[p] && we[p] && !wbit[p] && int'(idx[p*IW +: IW]) == l && pid(p) == m_owner[l]) begin
            nl[l] = 0; no[l] = 0;
          end
      end
    end
    for (int l = 0; l < L; l++) begin m_locked[l] = nl[l]; m_owner[l] = no[l]; end
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < P; p++) begin
      int gd = int'(rsp_data[p*4 +: 4]);
      vectors++;
      if (int'(rsp_valid[p]) != exp_v[p] || (exp_v[p] == 1 && gd != exp_d[p])) begin
        miscompares++;
        $display("FAIL %s port %0d: got valid=%0d data=%0d, expected valid=%0d data=%0d",
                 tag, p, rsp_valid[p], gd, exp_v[p], exp_d[p]);
      end
    end
    clr();
  endtask

  task automatic rd(int p, int l, string tag);
    op(p, 1'b0, 1'b0, l); step(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    clr();
    for (int l = 0; l < L; l++) begin m_locked[l] = 0; m_owner[l] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: every lock free, owner 0 after reset
    for (int l = 0; l < L; l += P) begin
      for (int p = 0; p < P; p++) op(p, 1'b0, 1'b0, l + p);
      step("R1");
    end
    // R10: idle cycle gives no response
    step("R10");

    // R3 / R2: port1 (ID 2) takes lock 3, reads 4'h5
    op(1, 1'b1, 1'b1, 3); step("R3");
    rd(1, 3, "R2");
    // R4: port2 (ID 5) tries lock 3; R10: no response after a write
    op(2, 1'b1, 1'b1, 3); step("R4");
    rd(2, 3, "R4");
    // R5: owner re-locks
    op(1, 1'b1, 1'b1, 3); step("R5");
    rd(0, 3, "R5");
    // R7: foreign release and release of a free lock
    op(0, 1'b1, 1'b0, 3); op(2, 1'b1, 1'b0, 9); step("R7");
    op(0, 1'b0, 1'b0, 3); op(3, 1'b0, 1'b0, 9); step("R7");
    // R2: read in same cycle as owner release returns pre-write value
    op(1, 1'b1, 1'b0, 3); op(0, 1'b0, 1'b0, 3); step("R2");
    rd(3, 3, "R6");
    // R8: ports 0,2,3 contend for lock 7 -> port0 (ID 1)
    op(0, 1'b1, 1'b1, 7); op(2, 1'b1, 1'b1, 7); op(3, 1'b1, 1'b1, 7); step("R8");
    rd(2, 7, "R8");
    // R8: ports 2,3 contend for lock 12 -> port2 (ID 5)
    op(2, 1'b1, 1'b1, 12); op(3, 1'b1, 1'b1, 12); step("R8");
    rd(0, 12, "R8");
    // R9: different locks same cycle
    op(1, 1'b1, 1'b1, 8); op(3, 1'b1, 1'b1, 9); step("R9");
    op(0, 1'b0, 1'b0, 8); op(2, 1'b0, 1'b0, 9); step("R9");
    // R4: owner release and foreign lock in same cycle -> ends free
    op(0, 1'b1, 1'b0, 7); op(1, 1'b1, 1'b1, 7); step("R4");
    rd(3, 7, "R6");

    // mixed random traffic on a few locks
    for (int i = 0; i < 600; i++) begin
      for (int p = 0; p < P; p++)
        if ($urandom_range(0, 3) != 0)
          op(p, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), int'($urandom_range(0, 3)));
      step("R9");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule